// File: doc/BRIEF.md
# Dual-Flash Parallel Read Combiner

This block sits on the receive side of a controller that drives two identical quad-SPI flash devices side by side, which gives an 8-bit path to storage. On every flash clock that carries data, the block takes one 4-bit sample from each device's IO lines and builds a byte from the pair. A mode input selects how the byte is built. For a data read, bits are interleaved between the two devices. For an identification read, only the lower device is used. For a status read, the lower device supplies the byte and the busy flags of both devices are OR-ed together.

Completed bytes are packed into 32-bit words, first byte lowest, and handed to a receive FIFO as a one-cycle word strobe. A flush at the end of a transfer pushes out a partly filled word together with its byte count. A synchronous clear at the start of each command discards any partial state. The same block also turns a linear-mode bus byte address into the per-device flash address, refuses misaligned requests, and reports the combined erase span of a broadcast sector erase.

Top module: `qd_pair_rx`

## Requirements
- R1: When `rd_mode`=0 (data read), every accepted sample yields a byte on `byte_out`, with `byte_vld` high one clock later. Byte bit 2i is `lo_nib[i]` and byte bit 2i+1 is `up_nib[i]`, for i = 0..3.
- R2: When `rd_mode`=1 (identification read), a byte takes two accepted samples from the lower device only. The first sample forms bits 7:4 and the second forms bits 3:0. `up_nib` has no effect, and `byte_vld` rises one clock after the second sample.
- R3: When `rd_mode`=2 (status read), bytes are assembled as in R2, except that bit 0 is the OR of `lo_nib[0]` and `up_nib[0]` in the second sample.
- R4: Every fourth byte completes a word. The word appears on `word_out` with `word_vld` high and `word_bytes`=4 one clock after the sample that completed the fourth byte. Byte k (k = 0..3, in arrival order) occupies bits 8k+7:8k.
- R5: When `flush` is high, any bytes still held, including one completed in that same cycle, are emitted one clock later. The unfilled upper bytes are zero and `word_bytes` gives the count. A flush with no bytes held emits nothing, and a flush that coincides with a fourth byte emits a single full word. A pending half byte (R2, R3) is not affected by flush.
- R6: When `clr` is high, any held bytes and any pending half byte are dropped, as is a sample offered in that cycle. Neither `byte_vld` nor `word_vld` is raised in the following cycle.
- R7: When `addr_req` is high and `bus_addr[1:0]`=0, `flash_req` is high and `flash_addr` equals `bus_addr` shifted right by one. The address path is combinational.
- R8: When `addr_req` is high and `bus_addr[1:0]` is nonzero, `addr_err` is high and `flash_req` is low. With `addr_req` low, both outputs are low.
- R9: `erase_span` equals twice the per-device sector size, which is 131072 at the defaults.
- R10: While `rst_n` is low, `byte_vld` and `word_vld` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Flash-side clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Start-of-command clear |
| rd_mode | input | 2 | 0 data, 1 identification, 2 status, 3 treated as data |
| smp_vld | input | 1 | A sample pair is present this cycle |
| lo_nib | input | 4 | IO[3:0] of the lower device |
| up_nib | input | 4 | IO[3:0] of the upper device |
| flush | input | 1 | End of transfer: emit a partial word |
| byte_out | output | 8 | Last assembled byte |
| byte_vld | output | 1 | byte_out is new this cycle |
| word_out | output | 32 | Packed word for the receive FIFO |
| word_vld | output | 1 | Word push strobe |
| word_bytes | output | 3 | Valid bytes in word_out (1..4) |
| addr_req | input | 1 | Linear-mode access request |
| bus_addr | input | 29 | Bus byte address |
| flash_req | output | 1 | Aligned request issued to the devices |
| flash_addr | output | 28 | Per-device address |
| addr_err | output | 1 | Misaligned request refused |
| erase_span | output | 32 | Combined bytes cleared by one sector erase |

## Verification
The cases that can share a cycle are a closing flush and byte completion, and in particular a flush that lands on the sample that fills the fourth byte. The bench drives flush on the same clock as the first, third and fourth byte of a word, and also drives it in random positions. A behavioural queue model, checked on every clock, requires exactly one word with the right count and zero fill. The bench also presents a sample in the same cycle as a clear, and checks that it leaves no trace in the next word.

// File: rtl/qd_pair_pkg.sv
package qd_pair_pkg;
   typedef enum logic [1:0] {
      RD_DATA   = 2'd0,
      RD_IDENT  = 2'd1,
      RD_STATUS = 2'd2,
      RD_SPARE  = 2'd3
   } rd_kind_e;
endpackage

// File: rtl/qd_byte_former.sv
module qd_byte_former
   import qd_pair_pkg::*;
#(
   parameter int NIB_W  = 4,
   localparam int BYTE_W = 2 * NIB_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  rd_kind_e          kind,
   input  logic              smp_vld,
   input  logic [NIB_W-1:0]  lo_nib,
   input  logic [NIB_W-1:0]  up_nib,
   output logic [BYTE_W-1:0] byte_o,
   output logic              byte_ok
);
   logic [NIB_W-1:0]  hi_q;
   logic              hi_have_q;
   logic [BYTE_W-1:0] mix;
   logic [BYTE_W-1:0] serial;
   logic [BYTE_W-1:0] stat;
   logic              serial_mode;

   // bit interleave: lower device on even bits, upper on odd bits
   for (genvar g = 0; g < NIB_W; g++) begin : g_mix
      assign mix[2*g]   = lo_nib[g];
      assign mix[2*g+1] = up_nib[g];
   end

   assign serial      = {hi_q, lo_nib};
   assign stat        = {hi_q, lo_nib[NIB_W-1:1], lo_nib[0] | up_nib[0]};
   assign serial_mode = (kind == RD_IDENT) || (kind == RD_STATUS);

   always_comb begin
      byte_o  = mix;
      byte_ok = smp_vld;
      unique case (kind)
         RD_IDENT: begin
            byte_o  = serial;
            byte_ok = smp_vld && hi_have_q;
         end
         RD_STATUS: begin
            byte_o  = stat;
            byte_ok = smp_vld && hi_have_q;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         hi_q      <= '0;
         hi_have_q <= 1'b0;
      end else if (smp_vld && serial_mode) begin
         if (hi_have_q) begin
            hi_have_q <= 1'b0;
         end else begin
            hi_q      <= lo_nib;
            hi_have_q <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/qd_word_packer.sv
module qd_word_packer #(
   parameter int BYTES  = 4,
   parameter int BYTE_W = 8,
   localparam int WORD_W = BYTES * BYTE_W,
   localparam int CNT_W  = $clog2(BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              in_vld,
   input  logic [BYTE_W-1:0] in_byte,
   input  logic              flush,
   output logic [WORD_W-1:0] word_o,
   output logic              word_vld,
   output logic [CNT_W-1:0]  word_cnt
);
   logic [WORD_W-1:0] acc_q, acc_n;
   logic [CNT_W-1:0]  cnt_q, cnt_n;
   logic              emit;

   always_comb begin
      acc_n = acc_q;
      cnt_n = cnt_q;
      if (in_vld) begin
         acc_n[cnt_q*BYTE_W +: BYTE_W] = in_byte;
         cnt_n = cnt_q + 1'b1;
      end
      emit = (cnt_n == CNT_W'(BYTES)) || (flush && (cnt_n != '0));
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         acc_q    <= '0;
         cnt_q    <= '0;
         word_vld <= 1'b0;
         word_o   <= '0;
         word_cnt <= '0;
      end else begin
         word_vld <= emit;
         if (emit) begin
            word_o   <= acc_n;
            word_cnt <= cnt_n;
            acc_q    <= '0;
            cnt_q    <= '0;
         end else begin
            acc_q    <= acc_n;
            cnt_q    <= cnt_n;
         end
      end
   end
endmodule

// File: rtl/qd_addr_map.sv
module qd_addr_map #(
   parameter int ADDR_W     = 29,
   parameter int ALIGN_BITS = 2,
   localparam int FA_W      = ADDR_W - 1
) (
   input  logic              addr_req,
   input  logic [ADDR_W-1:0] bus_addr,
   output logic              flash_req,
   output logic [FA_W-1:0]   flash_addr,
   output logic              addr_err
);
   logic misaligned;

   assign misaligned = |bus_addr[ALIGN_BITS-1:0];
   assign flash_addr = bus_addr[ADDR_W-1:1];
   assign flash_req  = addr_req && !misaligned;
   assign addr_err   = addr_req && misaligned;
endmodule

// File: rtl/qd_pair_rx.sv
module qd_pair_rx
   import qd_pair_pkg::*;
#(
   parameter int NIB_W        = 4,
   parameter int WORD_BYTES   = 4,
   parameter int ADDR_W       = 29,
   parameter int SECTOR_BYTES = 65536,
   parameter int SPAN_W       = 32,
   localparam int BYTE_W      = 2 * NIB_W,
   localparam int WORD_W      = WORD_BYTES * BYTE_W,
   localparam int CNT_W       = $clog2(WORD_BYTES + 1),
   localparam int FA_W        = ADDR_W - 1,
   localparam int ALIGN_BITS  = $clog2(WORD_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic [1:0]        rd_mode,
   input  logic              smp_vld,
   input  logic [NIB_W-1:0]  lo_nib,
   input  logic [NIB_W-1:0]  up_nib,
   input  logic              flush,
   output logic [BYTE_W-1:0] byte_out,
   output logic              byte_vld,
   output logic [WORD_W-1:0] word_out,
   output logic              word_vld,
   output logic [CNT_W-1:0]  word_bytes,
   input  logic              addr_req,
   input  logic [ADDR_W-1:0] bus_addr,
   output logic              flash_req,
   output logic [FA_W-1:0]   flash_addr,
   output logic              addr_err,
   output logic [SPAN_W-1:0] erase_span
);
   if (NIB_W != 4) begin : g_bad_nib
      $error("qd_pair_rx: NIB_W must be 4 so that a pair of samples forms a byte");
   end
   if (WORD_BYTES < 2 || (1 << ALIGN_BITS) != WORD_BYTES) begin : g_bad_word
      $error("qd_pair_rx: WORD_BYTES must be a power of two of at least 2");
   end
   if (ADDR_W <= ALIGN_BITS + 1) begin : g_bad_addr
      $error("qd_pair_rx: ADDR_W too small");
   end
   if (SPAN_W < $clog2(SECTOR_BYTES) + 2) begin : g_bad_span
      $error("qd_pair_rx: SPAN_W cannot hold the combined erase span");
   end

   rd_kind_e          kind;
   logic [BYTE_W-1:0] fb_byte;
   logic              fb_ok;
   logic              take;

   assign kind = rd_kind_e'(rd_mode);
   assign take = fb_ok && !clr;

   qd_byte_former #(.NIB_W(NIB_W)) i_former (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr),
      .kind    (kind),
      .smp_vld (smp_vld),
      .lo_nib  (lo_nib),
      .up_nib  (up_nib),
      .byte_o  (fb_byte),
      .byte_ok (fb_ok)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         byte_out <= '0;
         byte_vld <= 1'b0;
      end else begin
         byte_vld <= take;
         if (take) byte_out <= fb_byte;
      end
   end

   qd_word_packer #(.BYTES(WORD_BYTES), .BYTE_W(BYTE_W)) i_packer (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr),
      .in_vld   (take),
      .in_byte  (fb_byte),
      .flush    (flush),
      .word_o   (word_out),
      .word_vld (word_vld),
      .word_cnt (word_bytes)
   );

   qd_addr_map #(.ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS)) i_addr (
      .addr_req   (addr_req),
      .bus_addr   (bus_addr),
      .flash_req  (flash_req),
      .flash_addr (flash_addr),
      .addr_err   (addr_err)
   );

   assign erase_span = SPAN_W'(SECTOR_BYTES) << 1;
endmodule

// File: rtl/qd_pair_rx_chk.sv
module qd_pair_rx_chk #(
   parameter int WORD_BYTES = 4,
   parameter int ADDR_W     = 29,
   localparam int CNT_W     = $clog2(WORD_BYTES + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              clr,
   input logic [1:0]        rd_mode,
   input logic              smp_vld,
   input logic              flush,
   input logic              byte_vld,
   input logic              word_vld,
   input logic [CNT_W-1:0]  word_bytes,
   input logic              addr_req,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              flash_req,
   input logic [ADDR_W-2:0] flash_addr,
   input logic              addr_err
);
   p_data_byte_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_vld && !clr && (rd_mode == 2'd0)) |=> byte_vld);

   p_byte_needs_sample_r2: assert property (@(posedge clk) disable iff (!rst_n)
      byte_vld |-> $past(smp_vld));

   p_word_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
      word_vld |-> (word_bytes != '0 && word_bytes <= CNT_W'(WORD_BYTES)));

   p_partial_flush_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (word_vld && word_bytes != CNT_W'(WORD_BYTES)) |-> $past(flush));

   p_clear_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (!byte_vld && !word_vld));

   p_addr_half_r7: assert property (@(posedge clk) disable iff (!rst_n)
      flash_req |-> (flash_addr == bus_addr[ADDR_W-1:1] && addr_req));

   p_misaligned_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_req && bus_addr[1:0] != 2'b00) |-> (addr_err && !flash_req));

   p_reset_quiet_r10: assert property (@(posedge clk)
      !rst_n |=> (!byte_vld && !word_vld));
endmodule

bind qd_pair_rx qd_pair_rx_chk #(.WORD_BYTES(WORD_BYTES), .ADDR_W(ADDR_W)) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .clr        (clr),
   .rd_mode    (rd_mode),
   .smp_vld    (smp_vld),
   .flush      (flush),
   .byte_vld   (byte_vld),
   .word_vld   (word_vld),
   .word_bytes (word_bytes),
   .addr_req   (addr_req),
   .bus_addr   (bus_addr),
   .flash_req  (flash_req),
   .flash_addr (flash_addr),
   .addr_err   (addr_err)
);

// File: tb/test_qd_pair_rx.sv
module test_qd_pair_rx;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n, clr, smp_vld, flush, addr_req;
   logic [1:0]  rd_mode;
   logic [3:0]  lo_nib, up_nib;
   logic [7:0]  byte_out;
   logic        byte_vld, word_vld, flash_req, addr_err;
   logic [31:0] word_out, erase_span;
   logic [2:0]  word_bytes;
   logic [28:0] bus_addr;
   logic [27:0] flash_addr;

   int n_total = 0;
   int n_fail  = 0;

   // behavioural model state
   bit         m_half;
   logic [3:0] m_hi;
   logic [7:0] m_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   qd_pair_rx i_qd_pair_rx (
      .clk(clk), .rst_n(rst_n), .clr(clr), .rd_mode(rd_mode), .smp_vld(smp_vld),
      .lo_nib(lo_nib), .up_nib(up_nib), .flush(flush), .byte_out(byte_out),
      .byte_vld(byte_vld), .word_out(word_out), .word_vld(word_vld),
      .word_bytes(word_bytes), .addr_req(addr_req), .bus_addr(bus_addr),
      .flash_req(flash_req), .flash_addr(flash_addr), .addr_err(addr_err),
      .erase_span(erase_span)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_total++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic step(input logic c, input logic [1:0] m, input logic s,
                       input logic [3:0] l, input logic [3:0] u, input logic f,
                       input string req);
      logic [7:0]  b;
      logic [31:0] w;
      bit          bv, wv;
      int          nb;
      @(negedge clk);
      clr = c; rd_mode = m; smp_vld = s; lo_nib = l; up_nib = u; flush = f;
      @(posedge clk);
      #1;
      bv = 0; wv = 0; b = '0; w = '0; nb = 0;
      if (c) begin
         m_half = 0;
         m_q.delete();
      end else begin
         if (s) begin
            if (m == 2'd1 || m == 2'd2) begin
               if (!m_half) begin
                  m_hi = l; m_half = 1;
               end else begin
                  b = {m_hi, l};
                  if (m == 2'd2) b[0] = l[0] | u[0];
                  m_half = 0; bv = 1;
               end
            end else begin
               for (int i = 0; i < 4; i++) begin
                  b[2*i] = l[i]; b[2*i+1] = u[i];
               end
               bv = 1;
            end
         end
         if (bv) m_q.push_back(b);
         if (m_q.size() == 4 || (f && m_q.size() > 0)) begin
            wv = 1; nb = m_q.size();
            for (int i = 0; i < nb; i++) w[8*i +: 8] = m_q[i];
            m_q.delete();
         end
      end
      check(req, "byte_vld", {31'd0, byte_vld}, {31'd0, bv});
      if (bv) check(req, "byte_out", {24'd0, byte_out}, {24'd0, b});
      check(req, "word_vld", {31'd0, word_vld}, {31'd0, wv});
      if (wv) begin
         check(req, "word_out", word_out, w);
         check(req, "word_bytes", {29'd0, word_bytes}, 32'(nb));
      end
   endtask

   task automatic addr_chk(input logic rq, input logic [28:0] a, input string req);
      bit mis;
      @(negedge clk);
      addr_req = rq; bus_addr = a;
      #1;
      mis = (a[1:0] != 2'b00);
      check(req, "flash_req", {31'd0, flash_req}, {31'd0, rq && !mis});
      check(req, "addr_err", {31'd0, addr_err}, {31'd0, rq && mis});
      if (rq && !mis) check(req, "flash_addr", {4'd0, flash_addr}, {4'd0, a[28:1]});
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_total++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
   end

   initial begin
      rst_n = 0; clr = 0; rd_mode = 0; smp_vld = 0; lo_nib = 0; up_nib = 0;
      flush = 0; addr_req = 0; bus_addr = '0;
      m_half = 0; m_hi = '0;
      repeat (3) @(posedge clk);
      #1;
      check("R10", "byte_vld in reset", {31'd0, byte_vld}, 32'd0);
      check("R10", "word_vld in reset", {31'd0, word_vld}, 32'd0);
      @(negedge clk); rst_n = 1;

      // R9 combined erase span
      check("R9", "erase_span", erase_span, 32'd131072);

      // R1 and R4: data read, full word, distinct patterns
      step(1, 2'd0, 0, 4'h0, 4'h0, 0, "R6");
      step(0, 2'd0, 1, 4'hF, 4'h0, 0, "R1");
      step(0, 2'd0, 1, 4'h0, 4'hF, 0, "R1");
      step(0, 2'd0, 0, 4'h3, 4'h3, 0, "R4");
      step(0, 2'd0, 1, 4'h5, 4'hA, 0, "R1");
      step(0, 2'd0, 1, 4'h9, 4'h6, 0, "R4");
      // R5: flush on the first byte, idle flush, flush on the third byte
      step(0, 2'd0, 1, 4'h1, 4'h8, 1, "R5");
      step(0, 2'd0, 0, 4'h0, 4'h0, 1, "R5");
      step(0, 2'd0, 1, 4'hC, 4'h2, 0, "R5");
      step(0, 2'd0, 1, 4'h7, 4'h1, 0, "R5");
      step(0, 2'd0, 1, 4'hE, 4'hB, 1, "R5");
      // R5: flush together with the fourth byte
      for (int k = 0; k < 4; k++)
         step(0, 2'd0, 1, 4'(k + 2), 4'(7 - k), k == 3, "R5");
      step(0, 2'd0, 0, 4'h0, 4'h0, 0, "R5");

      // R6: clear drops held bytes and a sample offered with it
      step(0, 2'd0, 1, 4'hA, 4'hA, 0, "R6");
      step(0, 2'd0, 1, 4'h5, 4'h5, 0, "R6");
      step(1, 2'd0, 1, 4'hF, 4'hF, 0, "R6");
      for (int k = 0; k < 4; k++) step(0, 2'd0, 1, 4'(k), 4'(k + 8), 0, "R6");

      // R2: identification read, upper bus toggling garbage
      step(1, 2'd1, 0, 4'h0, 4'h0, 0, "R2");
      for (int k = 0; k < 8; k++) step(0, 2'd1, 1, 4'(3 * k + 1), 4'(k * 5), 0, "R2");
      // R6: clear with a pending half byte
      step(0, 2'd1, 1, 4'hD, 4'hF, 0, "R6");
      step(1, 2'd1, 0, 4'h0, 4'h0, 0, "R6");
      step(0, 2'd1, 1, 4'h2, 4'hF, 0, "R2");
      step(0, 2'd1, 1, 4'h4, 4'hF, 1, "R2");

      // R3: status read, busy flag merged from both devices
      step(1, 2'd2, 0, 4'h0, 4'h0, 0, "R3");
      step(0, 2'd2, 1, 4'h8, 4'hF, 0, "R3");
      step(0, 2'd2, 1, 4'h0, 4'h1, 0, "R3");
      step(0, 2'd2, 1, 4'h4, 4'h0, 0, "R3");
      step(0, 2'd2, 1, 4'h3, 4'h0, 0, "R3");
      step(0, 2'd2, 1, 4'h0, 4'hE, 0, "R3");
      step(0, 2'd2, 1, 4'h2, 4'hE, 1, "R3");

      // random runs in each mode
      for (int r = 0; r < 3; r++) begin
         step(1, 2'(r), 0, 4'h0, 4'h0, 0, "R6");
         for (int k = 0; k < 150; k++)
            step(0, 2'(r), ($urandom % 4) != 0, 4'($urandom), 4'($urandom),
                 ($urandom % 9) == 0, r == 0 ? "R1" : (r == 1 ? "R2" : "R3"));
      end

      // R7 and R8: address mapping
      addr_chk(1, 29'h1FFF_FFFC, "R7");
      addr_chk(1, 29'h0000_0004, "R7");
      addr_chk(1, 29'h0ABC_DEF0, "R7");
      addr_chk(1, 29'h0000_0002, "R8");
      addr_chk(1, 29'h0000_0001, "R8");
      addr_chk(1, 29'h1FFF_FFFF, "R8");
      addr_chk(0, 29'h0000_0003, "R8");
      addr_chk(0, 29'h0000_0008, "R8");

      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
   end
endmodule